// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises characters onto a single output line in the usual asynchronous frame: a low start bit, seven or eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. A one-character holding register sits in front of the frame shifter. Software can therefore write the next character while the current one is still on the line. Frames follow each other with no idle gap when the next character is ready in time.

Pacing comes from an external bit-rate strobe `bit_tick`, which pulses for one clock at each bit boundary. The format is chosen at run time with three configuration inputs. Their values are captured when a character moves from the holding register into the shifter. A level-sensitive interrupt request tells software that the holding register can take another character. Removing the enable aborts any frame in progress and puts the line back to idle.

The frame sequencer has five named states. S_IDLE holds the line high. The transition S_IDLE→S_START happens on a strobe when the holding register is full. S_START→S_DATA always happens on the next strobe. S_DATA→S_PAR happens after the last data bit when parity is on, and S_DATA→S_STOP happens after the last data bit when parity is off. S_PAR→S_STOP happens on the next strobe. At the end of the final stop bit there are two exits: S_STOP→S_START when another character is waiting, and S_STOP→S_IDLE when none is. From any state, a low enable forces the sequencer to S_IDLE.

Top module: `uart_tx_dbuf`

## Requirements
- R1: On the strobe that moves a character into the shifter, `txd` goes low from the next clock and stays low for one strobe period (the start bit).
- R2: The data bits follow the start bit least significant bit first, one per strobe period: eight bits when `cfg_len8`=1, seven bits (bits 6..0) when `cfg_len8`=0.
- R3: `cfg_par`=2'b01 inserts an even parity bit and 2'b10 inserts an odd parity bit after the data bits; 2'b00 and 2'b11 insert none. Parity covers only the transmitted data bits, so bit 7 of the character has no effect in 7-bit mode.
- R4: The frame ends with one high stop bit when `cfg_stop2`=0 and two when `cfg_stop2`=1, each lasting one strobe period.
- R5: A transfer happens on a strobe when the holding register is full and the shifter is either idle or finishing its final stop bit. The cycle after the transfer, `hold_empty` reads 1.
- R6: While enabled and with nothing to send, `txd` is held high. A character that is waiting at the end of the final stop bit starts its start bit with no idle period in between.
- R7: A write (`wr_en`=1 while `tx_en`=1) loads `wr_data` and makes `hold_empty` read 0 on the next cycle. A write in the same cycle as a transfer keeps the new character, so the flag stays 0.
- R8: `tx_irq` equals `irq_en` AND `hold_empty` AND `tx_en`.
- R9: While `tx_en`=0, from the next clock `txd` is 1, any frame is abandoned, `hold_empty` is 1, and writes are ignored.
- R10: After reset, `txd`=1, `hold_empty`=1 and the sequencer is idle.
- R11: Format inputs are sampled at transfer; changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| bit_tick | input | 1 | One-clock strobe marking each bit boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to load |
| cfg_len8 | input | 1 | 1 = eight data bits, 0 = seven |
| cfg_par | input | 2 | 01 even parity, 10 odd parity, 00/11 none |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| irq_en | input | 1 | Transmit interrupt enable |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register empty flag |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The embedded assertions check four things on every clock. A rising empty flag while enabled is always paired with a low start bit. A write always clears the flag. An idle sequencer with nothing queued keeps the line high. A disabled cycle always leaves the line high and the flag set. The bench's reference model is the only place where bit ordering, parity values, stop-bit counts, back-to-back chaining, write and transfer collisions and mid-frame configuration changes are checked, because each of these needs a whole frame of history to judge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4
    } tx_state_e;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data  <= '0;
            hold_empty <= 1'b1;
        end else if (!tx_en) begin
            hold_empty <= 1'b1;
        end else if (wr_en) begin
            hold_data  <= wr_data;
            hold_empty <= 1'b0;
        end else if (take) begin
            hold_empty <= 1'b1;
        end
    end

    // R7
    write_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && tx_en) |-> !hold_empty);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              hold_empty,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              cfg_len8,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_stop2,
    output logic              take,
    output logic              seq_idle,
    output logic              txd
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    tx_state_e         state, state_d;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              len8_q, par_on_q, par_bit_q, stop2_q;
    logic [CNT_W-1:0]  last_idx, stop_lim;
    logic              final_stop;
    logic [DATA_W-1:0] load_val;

    assign last_idx   = len8_q ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W - 2);
    assign stop_lim   = CNT_W'(stop2_q);
    assign final_stop = (state == S_STOP) && (cnt == stop_lim);
    assign load_val   = cfg_len8 ? hold_data : {1'b0, hold_data[DATA_W-2:0]};
    assign take       = tx_en && bit_tick && !hold_empty &&
                        ((state == S_IDLE) || final_stop);
    assign seq_idle   = (state == S_IDLE);

    // next-state logic
    always_comb begin
        state_d = state;
        if (!tx_en) begin
            state_d = S_IDLE;
        end else if (bit_tick) begin
            unique case (state)
                S_IDLE:  if (take) state_d = S_START;
                S_START: state_d = S_DATA;
                S_DATA:  if (cnt == last_idx) state_d = par_on_q ? S_PAR : S_STOP;
                S_PAR:   state_d = S_STOP;
                S_STOP:  if (final_stop) state_d = take ? S_START : S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            len8_q    <= 1'b1;
            par_on_q  <= 1'b0;
            par_bit_q <= 1'b0;
            stop2_q   <= 1'b0;
        end else if (take) begin
            shreg     <= load_val;
            cnt       <= '0;
            len8_q    <= cfg_len8;
            par_on_q  <= (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
            par_bit_q <= (^load_val) ^ (cfg_par == PAR_ODD);
            stop2_q   <= cfg_stop2;
        end else if (tx_en && bit_tick) begin
            unique case (state)
                S_DATA: begin
                    if (cnt == last_idx) begin
                        cnt <= '0;
                    end else begin
                        cnt   <= cnt + 1'b1;
                        shreg <= shreg >> 1;
                    end
                end
                S_STOP:  cnt <= cnt + 1'b1;
                default: cnt <= '0;
            endcase
        end
    end

    // line output
    always_comb begin
        unique case (state)
            S_START: txd = 1'b0;
            S_DATA:  txd = shreg[0];
            S_PAR:   txd = par_bit_q;
            default: txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_len8,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_stop2,
    input  logic              irq_en,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_irq
);

    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              seq_idle;

    uart_tx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (take),
        .hold_data  (hold_data),
        .hold_empty (hold_empty)
    );

    uart_tx_framer #(.DATA_W(DATA_W)) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .bit_tick   (bit_tick),
        .hold_empty (hold_empty),
        .hold_data  (hold_data),
        .cfg_len8   (cfg_len8),
        .cfg_par    (cfg_par),
        .cfg_stop2  (cfg_stop2),
        .take       (take),
        .seq_idle   (seq_idle),
        .txd        (txd)
    );

    assign tx_irq = irq_en & hold_empty & tx_en;

    // R1 R5
    start_on_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $rose(hold_empty)) |-> !txd);

    // R9
    disabled_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_en) |-> (txd && hold_empty));

    // R6
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_en) && $past(hold_empty) && $past(seq_idle)) |-> txd);

endmodule

// File: tb/uart_tx_dbuf_tb_top.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cfg_len8 = 1'b1;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_stop2 = 1'b0;
    logic       irq_en = 1'b0;
    logic       txd, hold_empty, tx_irq;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    bit tick_on = 1'b1;
    bit finished = 1'b0;

    uart_tx_dbuf dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_data(wr_data), .cfg_len8(cfg_len8),
        .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .irq_en(irq_en),
        .txd(txd), .hold_empty(hold_empty), .tx_irq(tx_irq)
    );

    always #4 clk = ~clk;

    // reference model state
    bit    m_cur = 1'b1;
    string m_tag = "R10";
    bit    m_empty = 1'b1;
    string m_etag = "R10";
    bit    mq[$];
    string mtq[$];
    string scen = "";

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    function automatic void build_frame(logic [7:0] d);
        int  n = cfg_len8 ? 8 : 7;
        bit  p = 1'b0;
        for (int i = 0; i < n; i++) begin
            mq.push_back(d[i]); mtq.push_back({"R2", scen});
            p ^= d[i];
        end
        if (cfg_par == 2'b01) begin mq.push_back(p);  mtq.push_back({"R3", scen}); end
        if (cfg_par == 2'b10) begin mq.push_back(!p); mtq.push_back({"R3", scen}); end
        mq.push_back(1'b1); mtq.push_back({"R4", scen});
        if (cfg_stop2) begin mq.push_back(1'b1); mtq.push_back({"R4", scen}); end
    endfunction

    logic [7:0] m_hold = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = 1'b1; m_tag = "R10"; m_empty = 1'b1; m_etag = "R10";
            mq.delete(); mtq.delete();
        end else if (!tx_en) begin
            m_cur = 1'b1; m_tag = "R9"; m_empty = 1'b1; m_etag = "R9";
            mq.delete(); mtq.delete();
        end else begin
            m_etag = "R5";
            if (bit_tick) begin
                if (mq.size() > 0) begin
                    m_cur = mq.pop_front(); m_tag = mtq.pop_front();
                end else if (!m_empty) begin
                    build_frame(m_hold);
                    m_cur = 1'b0; m_tag = {"R1", scen}; m_empty = 1'b1;
                end else begin
                    m_cur = 1'b1; m_tag = "R6";
                end
            end
            if (wr_en) begin
                m_hold = wr_data; m_empty = 1'b0; m_etag = "R7";
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            chk(txd === m_cur, m_tag, "txd", int'(txd), int'(m_cur));
            chk(hold_empty === m_empty, m_etag, "hold_empty", int'(hold_empty), int'(m_empty));
            chk(tx_irq === (irq_en & m_empty & tx_en), "R8", "tx_irq",
                int'(tx_irq), int'(irq_en & m_empty & tx_en));
        end
    end

    // bit-rate strobe: one pulse every 4 cycles
    always @(negedge clk) begin
        #1;
        cyc++;
        bit_tick = tick_on && (cyc % 4 == 0);
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(logic [7:0] d);
        @(negedge clk); #2;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic fmt(bit l8, logic [1:0] p, bit s2);
        @(negedge clk); #2;
        cfg_len8 = l8; cfg_par = p; cfg_stop2 = s2;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        summary();
    end

    initial begin
        idle(3);
        // R10 reset state
        chk(txd === 1'b1, "R10", "txd in reset", int'(txd), 1);
        chk(hold_empty === 1'b1, "R10", "hold_empty in reset", int'(hold_empty), 1);
        @(negedge clk); #2; rst_n = 1'b1;
        idle(2);
        chk(txd === 1'b1 && hold_empty === 1'b1, "R10", "idle after reset",
            int'({txd, hold_empty}), 3);
        @(negedge clk); #2; tx_en = 1'b1; irq_en = 1'b1;
        idle(10);

        // 8N1 single frame
        fmt(1'b1, 2'b00, 1'b0);
        put(8'hA5);
        idle(60);

        // 8E2 back-to-back frames
        fmt(1'b1, 2'b01, 1'b1);
        put(8'h3C); idle(6); put(8'h81);
        idle(130);

        // 7O1 with bit 7 set (ignored)
        fmt(1'b0, 2'b10, 1'b0);
        put(8'hC3); idle(3); put(8'h43);
        idle(110);

        // 7E2, 8O1, parity code 11 = none
        fmt(1'b0, 2'b01, 1'b1); put(8'hFF); idle(60);
        fmt(1'b1, 2'b10, 1'b0); put(8'h00); idle(60);
        fmt(1'b1, 2'b11, 1'b1); put(8'h5A); idle(60);

        // write/transfer collisions at every strobe phase
        fmt(1'b1, 2'b01, 1'b0);
        for (int off = 0; off < 4; off++) begin
            idle(off);
            put(8'h10 + 8'(off));
            put(8'h20 + 8'(off));
            irq_en = (off % 2 == 0);
            idle(110);
        end
        irq_en = 1'b1;

        // R11: change format mid-frame
        scen = " R11";
        fmt(1'b1, 2'b10, 1'b1);
        put(8'h96);
        idle(12);
        fmt(1'b0, 2'b00, 1'b0);
        idle(60);
        scen = "";
        idle(10);

        // R9: abort mid-frame, writes ignored while disabled
        fmt(1'b1, 2'b00, 1'b0);
        put(8'hE7);
        idle(14);
        @(negedge clk); #2; tx_en = 1'b0;
        idle(3);
        put(8'h55);
        idle(3);
        chk(hold_empty === 1'b1, "R9", "write while disabled ignored", int'(hold_empty), 1);
        @(negedge clk); #2; tx_en = 1'b1;
        idle(20);
        chk(txd === 1'b1, "R9", "line idle after re-enable", int'(txd), 1);

        // queue resumes normally
        put(8'h7E); idle(60);

        summary();
    end

endmodule